// File: doc/BRIEF.md
# High-Address Latch and Chip-Select Decoder

On some CPU buses the high and low halves of a memory address share the same pins and arrive at different times. This block catches the six high-order address bits while the address strobe is high and holds them after the strobe falls. Four of the held bits go out unchanged as the high address lines (system bits 8 to 11). The other two bits pick one of four active-low chip selects. Each chip select covers one 4K-byte region, so one block can decode a 16K-byte space.

An active-low chip enable gates the decoder. A build-time mode adds a second gate. In that mode a chip select can go low only while the memory read strobe or the memory write strobe is also low. This keeps memories that have no output enable from driving the bus while the CPU drives it. In the ungated mode the two strobe inputs are ignored, and read control is left to each memory's own output enable.

Top module: `hiaddr_latch_decoder`

## Requirements
- R1: While `strobe` is high, the latch is transparent, so `addr_hi` equals `addr_in[3:0]` in the same cycle.
- R2: On the falling edge of `strobe`, the address is frozen. While `strobe` stays low, changes on `addr_in` do not change `addr_hi` or `cs_n`.
- R3: `addr_hi` carries latched bits 3:0 in the same bit order (bit 0 goes to `addr_hi[0]`).
- R4: When enabled, a latched value n on bits 5:4 drives `cs_n[n]` low and the other three high. No more than one chip select is ever low.
- R5: While `ce_n` is high, all four `cs_n` outputs are high, whatever the latched address.
- R6: In the gated mode (`GATE_MODE` = GATE_RW), the chip selects are all high unless `rd_n` or `wr_n` is also low.
- R7: Changes on `ce_n`, `rd_n` and `wr_n` act on `cs_n` at once, with no new strobe edge needed.
- R8: `addr_hi` does not depend on `ce_n`, `rd_n` or `wr_n`.
- R9: In the ungated mode (`GATE_MODE` = GATE_NONE), `rd_n` and `wr_n` have no effect, and a low `ce_n` alone enables the decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_in | input | 6 | Multiplexed high-order address bits from the CPU |
| strobe | input | 1 | Address strobe. High means transparent; the value is held on the falling edge |
| ce_n | input | 1 | Active-low decoder enable |
| rd_n | input | 1 | Active-low memory read strobe (used only in the gated mode) |
| wr_n | input | 1 | Active-low memory write strobe (used only in the gated mode) |
| addr_hi | output | 4 | Latched high address bits 8 to 11 |
| cs_n | output | 4 | Active-low chip selects, one per 4K-byte region |

## Verification
The decoder is swept over all 64 address values with the strobe high. This separates a wrong bit order on `addr_hi` from a wrong mapping of bits 5:4 onto the chip selects. An address that changes after the strobe falls shows whether the latch holds or stays transparent. All eight combinations of enable, read and write are applied to both build modes against the same held address. These combinations separate gating by chip enable, gating by the read/write strobes, and leaking of the read/write strobes into the ungated mode. Toggling the enable without a strobe edge shows that the gating is combinational and not captured with the address.

// File: rtl/mald_pkg.sv
package mald_pkg;

    // Selects how the decoder enable is formed.
    typedef enum logic {
        GATE_NONE = 1'b0,   // chip enable alone
        GATE_RW   = 1'b1    // chip enable plus a read or write strobe
    } gate_mode_e;

    // Decoder enable from the active-low controls.
    function automatic logic decode_allowed(gate_mode_e mode, logic ce_n,
                                            logic rd_n, logic wr_n);
        logic strobe_ok;
        strobe_ok = (mode == GATE_NONE) ? 1'b1 : (~rd_n | ~wr_n);
        return ~ce_n & strobe_ok;
    endfunction

endpackage

// File: rtl/mald_addr_latch.sv
module mald_addr_latch #(
    parameter int WIDTH = 6
) (
    input  logic             open_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    // Level-sensitive capture: transparent while open, held after it closes.
    always_latch begin
        if (open_i) q_o <= d_i;
    end

endmodule

// File: rtl/mald_enable_gate.sv
module mald_enable_gate
    import mald_pkg::*;
#(
    parameter gate_mode_e MODE = GATE_RW
) (
    input  logic ce_n_i,
    input  logic rd_n_i,
    input  logic wr_n_i,
    output logic en_o
);

    generate
        if (MODE == GATE_RW) begin : g_rw
            assign en_o = decode_allowed(GATE_RW, ce_n_i, rd_n_i, wr_n_i);
        end else begin : g_plain
            logic unused_strobes;
            assign unused_strobes = rd_n_i ^ wr_n_i;
            assign en_o = decode_allowed(GATE_NONE, ce_n_i, 1'b1, 1'b1);
        end
    endgenerate

endmodule

// File: rtl/mald_sel_decoder.sv
module mald_sel_decoder #(
    parameter int SEL_BITS = 2,
    localparam int OUTS    = 1 << SEL_BITS
) (
    input  logic [SEL_BITS-1:0] sel_i,
    input  logic                en_i,
    output logic [OUTS-1:0]     sel_n_o
);

    generate
        for (genvar g = 0; g < OUTS; g++) begin : g_out
            assign sel_n_o[g] = ~(en_i && (sel_i == SEL_BITS'(g)));
        end
    endgenerate

endmodule

// File: rtl/hiaddr_latch_decoder.sv
module hiaddr_latch_decoder
    import mald_pkg::*;
#(
    parameter int         HI_BITS   = 4,
    parameter int         SEL_BITS  = 2,
    parameter gate_mode_e GATE_MODE = GATE_RW
) (
    input  logic [HI_BITS+SEL_BITS-1:0] addr_in,
    input  logic                        strobe,
    input  logic                        ce_n,
    input  logic                        rd_n,
    input  logic                        wr_n,
    output logic [HI_BITS-1:0]          addr_hi,
    output logic [(1<<SEL_BITS)-1:0]    cs_n
);

    localparam int ADDR_W = HI_BITS + SEL_BITS;

    logic [ADDR_W-1:0] held;
    logic              dec_en;

    mald_addr_latch #(.WIDTH(ADDR_W)) u_latch (
        .open_i (strobe),
        .d_i    (addr_in),
        .q_o    (held)
    );

    mald_enable_gate #(.MODE(GATE_MODE)) u_gate (
        .ce_n_i (ce_n),
        .rd_n_i (rd_n),
        .wr_n_i (wr_n),
        .en_o   (dec_en)
    );

    mald_sel_decoder #(.SEL_BITS(SEL_BITS)) u_dec (
        .sel_i   (held[ADDR_W-1:HI_BITS]),
        .en_i    (dec_en),
        .sel_n_o (cs_n)
    );

    assign addr_hi = held[HI_BITS-1:0];

endmodule

// File: rtl/mald_checker.sv
module mald_checker
    import mald_pkg::*;
#(
    parameter int         HI_BITS   = 4,
    parameter int         SEL_BITS  = 2,
    parameter gate_mode_e GATE_MODE = GATE_RW
) (
    input logic [HI_BITS+SEL_BITS-1:0] addr_in,
    input logic                        strobe,
    input logic                        ce_n,
    input logic                        rd_n,
    input logic                        wr_n,
    input logic [HI_BITS-1:0]          addr_hi,
    input logic [(1<<SEL_BITS)-1:0]    cs_n
);

    logic strobes_idle;
    assign strobes_idle = rd_n & wr_n;

    always_comb begin
        // R4: never more than one chip select active
        a_r4_onehot: assert ($onehot0(~cs_n));
        // R5: a high enable blocks every chip select
        if (ce_n) begin
            a_r5_ce_blocks: assert (&cs_n);
        end
        // R6: in the gated mode, idle read and write strobes block every chip select
        if (GATE_MODE == GATE_RW && strobes_idle) begin
            a_r6_rw_blocks: assert (&cs_n);
        end
        // R1: the high address follows the input while the strobe is high
        if (strobe) begin
            a_r1_pass: assert (addr_hi == addr_in[HI_BITS-1:0]);
        end
        // R4: with the latch open and the decoder enabled, the addressed select is low
        if (strobe && !ce_n && (GATE_MODE == GATE_NONE || !strobes_idle)) begin
            a_r4_select: assert (cs_n[addr_in[HI_BITS +: SEL_BITS]] == 1'b0);
        end
    end

endmodule

bind hiaddr_latch_decoder mald_checker #(
    .HI_BITS   (HI_BITS),
    .SEL_BITS  (SEL_BITS),
    .GATE_MODE (GATE_MODE)
) u_mald_chk (
    .addr_in (addr_in),
    .strobe  (strobe),
    .ce_n    (ce_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr_hi (addr_hi),
    .cs_n    (cs_n)
);

// File: tb/tb_hiaddr_latch_decoder.sv
module tb_hiaddr_latch_decoder;
    import mald_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [5:0] addr_in = '0;
    logic       strobe  = 1'b0;
    logic       ce_n    = 1'b1;
    logic       rd_n    = 1'b1;
    logic       wr_n    = 1'b1;
    logic [3:0] hi_g, hi_u, cs_g, cs_u;

    hiaddr_latch_decoder #(.GATE_MODE(GATE_RW)) dut (
        .addr_in (addr_in), .strobe (strobe), .ce_n (ce_n),
        .rd_n (rd_n), .wr_n (wr_n), .addr_hi (hi_g), .cs_n (cs_g)
    );

    hiaddr_latch_decoder #(.GATE_MODE(GATE_NONE)) dut_ug (
        .addr_in (addr_in), .strobe (strobe), .ce_n (ce_n),
        .rd_n (rd_n), .wr_n (wr_n), .addr_hi (hi_u), .cs_n (cs_u)
    );

    typedef struct {
        logic [3:0] hi;
        logic [3:0] cs_gated;
        logic [3:0] cs_plain;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    logic [5:0] model_held = '0;
    bit   done = 0;

    function automatic logic [3:0] ref_cs(logic [1:0] sel, logic en);
        logic [3:0] r;
        r = 4'hF;
        if (en) r[sel] = 1'b0;
        return r;
    endfunction

    // Driver: applies one input set and queues the values the requirements predict.
    task automatic drive(logic s, logic [5:0] a, logic ce, logic rd, logic wr, string req);
        exp_t e;
        @(posedge clk);
        #1;
        strobe = s; addr_in = a; ce_n = ce; rd_n = rd; wr_n = wr;
        if (s) model_held = a;
        e.hi       = model_held[3:0];
        e.cs_gated = ref_cs(model_held[5:4], !ce && (!rd || !wr));
        e.cs_plain = ref_cs(model_held[5:4], !ce);
        e.req      = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compares at the falling clock edge.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_run++;
                if (hi_g !== e.hi || cs_g !== e.cs_gated || hi_u !== e.hi || cs_u !== e.cs_plain) begin
                    n_fail++;
                    $display("FAIL %s: hi=%h/%h cs=%b/%b expected hi=%h cs=%b/%b",
                             e.req, hi_g, hi_u, cs_g, cs_u, e.hi, e.cs_gated, e.cs_plain);
                end
            end
        end
    end

    initial begin
        int wd = 0;
        while (!done && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1 R3 R4: open latch, select region 0
        drive(1, 6'b00_0101, 0, 0, 1, "R1 R3 R4 pass region0");
        drive(1, 6'b10_1010, 0, 0, 1, "R1 R4 pass region2");
        // R2: close the latch, then move the input
        drive(0, 6'b10_1010, 0, 0, 1, "R2 freeze at fall");
        drive(0, 6'b01_0011, 0, 0, 1, "R2 input ignored while closed");
        // R5 R8: chip enable high blocks selects, high bits untouched
        drive(0, 6'b01_0011, 1, 0, 1, "R5 R8 ce_n high");
        // R6 R9: idle read/write strobes block only the gated mode
        drive(0, 6'b01_0011, 0, 1, 1, "R6 R9 strobes idle");
        // R7: write strobe enables without a new latch edge
        drive(0, 6'b01_0011, 0, 1, 0, "R7 write strobe immediate");
        drive(0, 6'b01_0011, 1, 1, 0, "R7 R8 ce_n rises immediate");
        // R3 R4: sweep every address with latch open
        for (int a = 0; a < 64; a++) begin
            drive(1, 6'(a), 0, 0, 1, "R3 R4 sweep");
        end
        // R5 R6 R9: every control combination on a held address
        drive(1, 6'b11_0110, 0, 0, 0, "R4 load region3");
        for (int c = 0; c < 8; c++) begin
            drive(0, 6'b00_1001, c[2], c[1], c[0], "R5 R6 R8 R9 controls");
        end
        // R2: second freeze with a different value
        drive(1, 6'b01_1100, 0, 0, 0, "R1 load region1");
        drive(0, 6'b01_1100, 0, 0, 0, "R2 fall");
        drive(0, 6'b10_0001, 0, 0, 0, "R2 hold region1");
        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule